// File: doc/BRIEF.md
# Iterative ARX Block Encryption Engine

This block encrypts one 64-bit block at a time. The block is split into four 16-bit quarters. Each quarter is rotated right by a fixed amount: 7 bits for the first and third quarters and 2 bits for the second and fourth. The first rotated quarter is then added to a 16-bit subkey. The other three are chained to it with XORs, and the four results go back in a rotated quarter order. The engine computes exactly one such stage per clock. It runs 25 stages, arranged as 5 rounds of 5 stages, and every stage uses its own subkey.

Subkeys come from a separate key-schedule block through a narrow lookup port. On every busy cycle the engine drives the round and stage index of the stage it is working on. The key-schedule block returns the 16-bit subkey combinationally, in the same cycle.

The plaintext arrives on a valid/ready input stream. The engine takes a block only when it is idle, so `in_ready` is low for the whole computation. That is the only back-pressure. The output side has no ready: a one-cycle done pulse marks a fresh ciphertext. The ciphertext register then holds that value until the next block completes, so the consumer can read it at any time before then.

Top module: `arx_enc_core`

## Requirements
- R1: The stage input is split into quarters with P1 at bits 63:48, down to P4 at bits 15:0. The first stage result is M1 = rotr(P1,7) + k modulo 2^16, where k is `key_word`.
- R2: The other stage results form a chain: M2 = rotr(P2,2) XOR M1, M3 = rotr(P3,7) XOR M2 and M4 = rotr(P4,2) XOR M3.
- R3: The stage output, from bit 63 down, is {M2, M3, M4, M1}, and it becomes the input of the next stage.
- R4: Stage number n runs from 0 to 24 and is computed on the n-th busy cycle after acceptance. In that cycle the engine drives `key_round` = n/5 and `key_stage` = n%5 and uses `key_word` from the same cycle. The output after stage 24 is the ciphertext.
- R5: `in_ready` equals the inverse of `busy`. A transfer (in_valid and in_ready at a clock edge) loads `in_block` and raises `busy` on the next cycle.
- R6: `out_done` is high for exactly one cycle. That cycle is 25 clock edges after the accepting edge. In the same cycle `busy` returns low and `out_block` carries the new ciphertext.
- R7: An `in_valid` asserted while busy is not taken. The current result is unaffected, and no extra result is produced.
- R8: `out_block` changes only on the edge that raises `out_done`, and otherwise holds its value.
- R9: Synchronous active-high `rst` clears `busy` and `out_done`, zeroes `out_block`, and abandons any computation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Engine idle, ready to take a block |
| in_block | input | 64 | Plaintext block |
| key_round | output | 3 | Round index of the subkey requested |
| key_stage | output | 3 | Stage index within the round of the subkey requested |
| key_word | input | 16 | Subkey returned for the requested index |
| out_block | output | 64 | Ciphertext, held until the next completion |
| out_done | output | 1 | One-cycle pulse: new ciphertext present |
| busy | output | 1 | Encryption in progress |

## Verification
The bench gives each of the 25 (round, stage) pairs a different subkey. An engine that addressed the key port with an off-by-one index, or that wrapped the stage counter wrongly, therefore yields a wrong ciphertext, and an address check on every busy cycle flags it. Several plaintexts isolate parts of the stage. All-ones inputs and carry-heavy inputs expose an addition that drops or leaks carries. Single-bit inputs expose a swapped rotation amount or a misordered quarter output. The bench keeps `in_valid` high with a different block during a computation: a design that accepted it would corrupt the result or emit a second done. It also checks that the ciphertext holds after done, and that a reset mid-run leaves no stray completion.

// File: rtl/arx_pkg.sv
package arx_pkg;
  // quarters per block; the stage output order depends on it
  localparam int unsigned NQ = 4;

  // even-numbered quarters (from MSB) take the first rotation, odd ones the second
  function automatic int unsigned rot_for(input int unsigned q, input int unsigned ra,
                                          input int unsigned rb);
    return (q % 2 == 0) ? ra : rb;
  endfunction
endpackage

// File: rtl/arx_stage.sv
module arx_stage
  import arx_pkg::*;
#(
  parameter int unsigned QW    = 16,
  parameter int unsigned ROT_A = 7,
  parameter int unsigned ROT_B = 2,
  localparam int unsigned BW   = NQ * QW
) (
  input  logic [BW-1:0] din,
  input  logic [QW-1:0] subkey,
  output logic [BW-1:0] dout
);
  logic [QW-1:0] quarter [NQ];
  logic [QW-1:0] rotated [NQ];
  logic [QW-1:0] mixed   [NQ];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    localparam int unsigned RA = rot_for(q, ROT_A, ROT_B);
    assign quarter[q] = din[BW-1-q*QW -: QW];
    assign rotated[q] = {quarter[q][RA-1:0], quarter[q][QW-1:RA]};
    if (q == 0) begin : g_add
      assign mixed[q] = rotated[q] + subkey;
    end else begin : g_xor
      assign mixed[q] = rotated[q] ^ mixed[q-1];
    end
    // output quarter q takes the result one place further down the chain
    assign dout[BW-1-q*QW -: QW] = mixed[(q+1) % NQ];
  end
endmodule

// File: rtl/arx_stage_ctr.sv
module arx_stage_ctr #(
  parameter int unsigned ROUNDS = 5,
  parameter int unsigned STAGES = 5,
  localparam int unsigned RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int unsigned SW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  output logic [RW-1:0] round_idx,
  output logic [SW-1:0] stage_idx,
  output logic          last
);
  logic [RW-1:0] round_q;
  logic [SW-1:0] stage_q;
  logic          stage_wrap;
  logic          round_wrap;

  assign stage_wrap = (stage_q == SW'(STAGES - 1));
  assign round_wrap = (round_q == RW'(ROUNDS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      round_q <= '0;
      stage_q <= '0;
    end else if (adv) begin
      if (stage_wrap) begin
        stage_q <= '0;
        round_q <= round_wrap ? '0 : round_q + 1'b1;
      end else begin
        stage_q <= stage_q + 1'b1;
      end
    end
  end

  assign round_idx = round_q;
  assign stage_idx = stage_q;
  assign last      = stage_wrap && round_wrap;
endmodule

// File: rtl/arx_enc_core.sv
module arx_enc_core
  import arx_pkg::*;
#(
  parameter int unsigned QW     = 16,
  parameter int unsigned ROUNDS = 5,
  parameter int unsigned STAGES = 5,
  parameter int unsigned ROT_A  = 7,
  parameter int unsigned ROT_B  = 2,
  localparam int unsigned BW    = NQ * QW,
  localparam int unsigned RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int unsigned SW    = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [BW-1:0] in_block,
  output logic [RW-1:0] key_round,
  output logic [SW-1:0] key_stage,
  input  logic [QW-1:0] key_word,
  output logic [BW-1:0] out_block,
  output logic          out_done,
  output logic          busy
);
  logic [BW-1:0] state_q;
  logic [BW-1:0] state_nxt;
  logic [BW-1:0] ct_q;
  logic          busy_q;
  logic          done_q;
  logic          accept;
  logic          last_stage;

  assign accept = in_valid && !busy_q;

  arx_stage_ctr #(
    .ROUNDS(ROUNDS),
    .STAGES(STAGES)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .adv      (busy_q),
    .round_idx(key_round),
    .stage_idx(key_stage),
    .last     (last_stage)
  );

  arx_stage #(
    .QW   (QW),
    .ROT_A(ROT_A),
    .ROT_B(ROT_B)
  ) u_stage (
    .din   (state_q),
    .subkey(key_word),
    .dout  (state_nxt)
  );

  // datapath register: no reset needed, it is always loaded before use
  always_ff @(posedge clk) begin
    if (accept) begin
      state_q <= in_block;
    end else if (busy_q) begin
      state_q <= state_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ct_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
      end else if (busy_q && last_stage) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        ct_q   <= state_nxt;
      end
    end
  end

  assign in_ready  = !busy_q;
  assign busy      = busy_q;
  assign out_done  = done_q;
  assign out_block = ct_q;
endmodule

// File: rtl/arx_enc_core_chk.sv
module arx_enc_core_chk #(
  parameter int unsigned BW     = 64,
  parameter int unsigned RW     = 3,
  parameter int unsigned SW     = 3,
  parameter int unsigned ROUNDS = 5,
  parameter int unsigned STAGES = 5,
  localparam int unsigned TOTAL = ROUNDS * STAGES,
  localparam int unsigned LW    = $clog2(TOTAL + 1) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          busy,
  input logic          out_done,
  input logic [BW-1:0] out_block,
  input logic [RW-1:0] key_round,
  input logic [SW-1:0] key_stage
);
  logic [LW-1:0] lat;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                     lat <= '0;
    else if (in_valid && in_ready) lat <= '0;
    else if (busy)               lat <= lat + 1'b1;
  end

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> busy);

  // R5
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

  // R4
  key_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, key_round} < (RW+1)'(ROUNDS)) && ({1'b0, key_stage} < (SW+1)'(STAGES)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);

  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> lat == LW'(TOTAL) && !busy);

  // R7
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && in_valid && !out_done && lat < LW'(TOTAL - 1) |=> busy);

  // R8
  ct_hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && !out_done |-> $stable(out_block));
endmodule

bind arx_enc_core arx_enc_core_chk #(
  .BW    (BW),
  .RW    (RW),
  .SW    (SW),
  .ROUNDS(ROUNDS),
  .STAGES(STAGES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .out_done (out_done),
  .out_block(out_block),
  .key_round(key_round),
  .key_stage(key_stage)
);

// File: tb/arx_enc_core_bench.sv
module arx_enc_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_block = '0;
  logic [2:0]  key_round;
  logic [2:0]  key_stage;
  logic [15:0] key_word;
  logic [63:0] out_block;
  logic        out_done;
  logic        busy;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int acc_last = 0;
  int n_done = 0;
  logic [63:0] exp_q[$];
  int          acc_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  arx_enc_core u_arx_enc_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .key_round(key_round), .key_stage(key_stage),
    .key_word(key_word), .out_block(out_block), .out_done(out_done), .busy(busy)
  );

  // key-schedule stand-in: a distinct subkey for every (round, stage)
  function automatic logic [15:0] kf(input int r, input int s);
    logic [15:0] v;
    v = 16'((r * 5 + s + 1) * 16'h9E37);
    return v ^ 16'hA5C3;
  endfunction

  always_comb key_word = kf(int'(key_round), int'(key_stage));

  function automatic logic [15:0] rr(input logic [15:0] x, input int n);
    return (x >> n) | (x << (16 - n));
  endfunction

  function automatic logic [63:0] model(input logic [63:0] pt);
    logic [63:0] s;
    logic [15:0] m1, m2, m3, m4;
    s = pt;
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 5; k++) begin
        m1 = rr(s[63:48], 7) + kf(r, k);
        m2 = rr(s[47:32], 2) ^ m1;
        m3 = rr(s[31:16], 7) ^ m2;
        m4 = rr(s[15:0], 2) ^ m3;
        s = {m2, m3, m4, m1};
      end
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [63:0] pt);
    @(negedge clk);
    in_valid = 1'b1;
    in_block = pt;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(model(pt));
    acc_q.push_back(cyc + 1);
    acc_last = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor: subkey addressing and scoreboard
  always @(negedge clk) begin
    if (!rst && busy) begin
      int idx;
      idx = cyc - acc_last;
      check({29'd0, key_round} == 32'(idx / 5) && {29'd0, key_stage} == 32'(idx % 5),
            "R4 key index", {58'd0, key_round, key_stage},
            64'(((idx / 5) << 3) | (idx % 5)));
    end
    if (!rst && out_done) begin
      n_done++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", out_block, 64'd0);
      end else begin
        logic [63:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        check(out_block == e, "R1 R2 R3 ciphertext", out_block, e);
        check(cyc - a == 25, "R6 latency", 64'(cyc - a), 64'd25);
        check(in_ready && !busy, "R5 R6 idle at done", {62'd0, in_ready, busy}, 64'd2);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    logic [63:0] held;
    logic [63:0] lcg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(!busy && !out_done, "R9 busy/done after reset", {62'd0, busy, out_done}, 64'd0);
    check(out_block == 64'd0, "R9 out_block after reset", out_block, 64'd0);
    check(in_ready, "R5 R9 ready after reset", {63'd0, in_ready}, 64'd1);

    // directed patterns
    send(64'd0);
    wait (exp_q.size() == 0); @(negedge clk);
    send(64'hFFFF_FFFF_FFFF_FFFF);
    wait (exp_q.size() == 0); @(negedge clk);
    send(64'h8000_0000_0000_0001);
    wait (exp_q.size() == 0); @(negedge clk);
    send(64'h0123_4567_89AB_CDEF);
    wait (exp_q.size() == 0); @(negedge clk);
    send(64'hFFFF_0000_FFFF_0000);
    wait (exp_q.size() == 0); @(negedge clk);

    // pseudo-random blocks
    lcg = 64'h2545_F491_4F6C_DD1D;
    for (int i = 0; i < 6; i++) begin
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      send(lcg);
      wait (exp_q.size() == 0); @(negedge clk);
    end

    // R7: offer a second block while busy
    n_done = 0;
    send(64'hDEAD_BEEF_0BAD_F00D);
    in_valid = 1'b1;
    in_block = 64'h1111_2222_3333_4444;
    @(negedge clk);
    check(!in_ready, "R5 R7 not ready while busy", {63'd0, in_ready}, 64'd0);
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    wait (exp_q.size() == 0);
    repeat (40) @(negedge clk);
    check(n_done == 1, "R7 single completion", 64'(n_done), 64'd1);

    // R8: ciphertext holds while idle
    held = out_block;
    repeat (6) @(negedge clk);
    check(out_block == held && !out_done, "R8 hold after done", out_block, held);

    // R8: holds during the next computation until its done
    send(64'h0F0F_F0F0_1234_8765);
    repeat (10) @(negedge clk);
    check(out_block == held, "R8 hold while busy", out_block, held);
    wait (exp_q.size() == 0); @(negedge clk);

    // R9: reset mid-run abandons the block
    send(64'hCAFE_CAFE_CAFE_CAFE);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    acc_q.delete();
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !out_done && out_block == 64'd0, "R9 reset mid-run",
          out_block, 64'd0);
    n_done = 0;
    repeat (40) @(negedge clk);
    check(n_done == 0, "R9 no stray done", 64'(n_done), 64'd0);

    // still works after reset
    send(64'h5555_AAAA_3333_CCCC);
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule